// File: doc/BRIEF.md
# Nanosecond-to-Cycle Timing Calculator

This block turns a set of external static-memory timing requirements, each given in nanoseconds, into whole clock-cycle counts for a memory clock whose rate is supplied in hertz. It first derives a 16.16 fixed-point cycles-per-nanosecond multiplier from the clock rate. A sequential restoring divider computes it in two passes so that no intermediate value overflows. It then converts fourteen nanosecond quantities one per cycle. Every conversion rounds up, so a strobe is never made shorter than requested.

Four strobes are handled: chip select for reads, the read strobe, chip select for writes and the write strobe. Each has a setup, a pulse and a recovery time. The read and write total cycle lengths are then enlarged so that every strobe's setup, pulse and recovery fit inside the total for its direction. A one-cycle start pulse launches the computation. When the ten result counts are valid, a one-cycle done pulse is given. The results hold until the next computation completes.

Top module: `mem_timing_calc`

## Requirements
- R1: The multiplier equals floor((floor(clk_hz / 10000) * 65536) / 100000). Every nonzero request converts with that multiplier for any 32-bit clk_hz.
- R2: A nonzero request of t ns becomes floor((t * multiplier + 65535) / 65536) cycles. Any fractional cycle rounds up, and an exact multiple does not gain a cycle.
- R3: A setup, pulse or total request of zero yields a count of zero and is not converted.
- R4: A recovery request of zero counts as one cycle. A nonzero recovery converts as in R2.
- R5: The read total (output slot 8) is the largest of these three values: the converted read total request, chip-select-read setup+pulse+recovery, and read-strobe setup+pulse+recovery.
- R6: The write total (output slot 9) is the largest of these three values: the converted write total request, chip-select-write setup+pulse+recovery, and write-strobe setup+pulse+recovery.
- R7: done is high for exactly one cycle per accepted start, and the outputs are valid in that cycle. The outputs do not change when the inputs change until the next done.
- R8: A start pulse that arrives while a computation is in progress is ignored. It does not alter the result being produced and it does not queue a second computation.
- R9: After reset, done is low and all output counts are zero.

Input request slot k occupies req_ns[16k+15:16k]. The slots are: 0/1/2 chip-select-read setup/pulse/recovery, 3/4/5 read-strobe setup/pulse/recovery, 6/7/8 chip-select-write setup/pulse/recovery, 9/10/11 write-strobe setup/pulse/recovery, 12 read total, 13 write total.

Output slot j occupies cyc_out[24j+23:24j]. The slots are: 0/1 chip-select-read setup/pulse, 2/3 read-strobe setup/pulse, 4/5 chip-select-write setup/pulse, 6/7 write-strobe setup/pulse, 8 read total, 9 write total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch pulse, honoured only when idle |
| clk_hz | input | 32 | Memory clock rate in Hz |
| req_ns | input | 224 | Fourteen 16-bit nanosecond requests |
| cyc_out | output | 240 | Ten 24-bit cycle counts |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench builds the block with its default parameters: a 32-bit rate, 16-bit requests and 24-bit counts. With these widths the full-scale case can be reached: a clock rate of 0xFFFFFFFF with every request at 65535 ns, where the three-term sums come close to 2^20 and must not wrap. Rates of 250 MHz and 1 GHz give multipliers of exactly 16384 and 65536. These values separate the round-up case from the exact-multiple case. A second start issued mid-computation exercises the idle-only acceptance.

// File: rtl/mem_timing_pkg.sv
package mem_timing_pkg;

    localparam int NUM_REQ   = 14;
    localparam int NUM_OUT   = 10;
    localparam int PER_DIR   = 6;   // request slots per direction (two strobes x three phases)
    localparam int TOTAL_RD  = 12;  // request slot of the read total
    localparam int OUT_TOT   = 8;   // output slot of the read total

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_PRE,
        CS_SCALE,
        CS_CONV,
        CS_FIT
    } calc_state_e;

    // Recovery slots are 2, 5, 8 and 11.
    function automatic logic is_recovery_slot(input int unsigned slot);
        return (slot < TOTAL_RD) && ((slot % 3) == 2);
    endfunction

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int DW = 48,   // dividend width
    parameter int VW = 17,   // divisor width
    parameter int QW = 32    // kept quotient width
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [QW-1:0] quotient,
    output logic          done
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [VW-1:0] rem;
        logic [DW-1:0] dvd;
        logic [QW-1:0] quo;
        logic [VW-1:0] dvs;
        logic          done;
    } div_regs_t;

    div_regs_t q, d;
    logic [VW:0] trial;
    logic [VW:0] diff;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.dvd[DW-1]};
        diff   = trial - {1'b0, q.dvs};
        if (!q.busy) begin
            if (go) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.rem  = '0;
                d.dvd  = dividend;
                d.quo  = '0;
                d.dvs  = divisor;
            end
        end else begin
            if (trial >= {1'b0, q.dvs}) begin
                d.rem = diff[VW-1:0];
                d.quo = {q.quo[QW-2:0], 1'b1};
            end else begin
                d.rem = trial[VW-1:0];
                d.quo = {q.quo[QW-2:0], 1'b0};
            end
            d.dvd = q.dvd << 1;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(DW - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quotient = q.quo;
    assign done     = q.done;

    // R1: the partial remainder stays below the divisor on every step.
    assert_rem_below_divisor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.rem < q.dvs));

    // R1: a result is never announced while a division is still running.
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.busy);

endmodule

// File: rtl/ns_to_cycles.sv
module ns_to_cycles #(
    parameter int NS_W   = 16,
    parameter int MUL_W  = 32,
    parameter int CYC_W  = 24,
    parameter int FRAC_W = 16
) (
    input  logic [NS_W-1:0]  ns,
    input  logic [MUL_W-1:0] mul,
    input  logic             recovery,
    output logic [CYC_W-1:0] cyc
);
    localparam int PW = NS_W + MUL_W;
    localparam logic [PW:0] ROUND = (PW + 1)'((64'd1 << FRAC_W) - 64'd1);

    logic [PW-1:0] product;
    logic [PW:0]   rounded;

    always_comb begin
        product = PW'(ns) * PW'(mul);
        rounded = {1'b0, product} + ROUND;
        if (ns == '0)
            cyc = recovery ? CYC_W'(1) : '0;
        else
            cyc = CYC_W'(rounded >> FRAC_W);
    end

endmodule

// File: rtl/fit_totals.sv
module fit_totals
    import mem_timing_pkg::*;
#(
    parameter int CYC_W = 24
) (
    input  logic [NUM_REQ-1:0][CYC_W-1:0] conv,
    output logic [NUM_OUT-1:0][CYC_W-1:0] res
);
    localparam int SW = CYC_W + 2;

    for (genvar g = 0; g < 2; g++) begin : g_dir
        logic [SW-1:0] sum_cs;
        logic [SW-1:0] sum_st;
        logic [SW-1:0] widest;

        always_comb begin
            sum_cs = SW'(conv[g*PER_DIR + 0]) + SW'(conv[g*PER_DIR + 1]) + SW'(conv[g*PER_DIR + 2]);
            sum_st = SW'(conv[g*PER_DIR + 3]) + SW'(conv[g*PER_DIR + 4]) + SW'(conv[g*PER_DIR + 5]);
            widest = SW'(conv[TOTAL_RD + g]);
            if (sum_cs > widest) widest = sum_cs;
            if (sum_st > widest) widest = sum_st;
        end

        assign res[4*g + 0]   = conv[g*PER_DIR + 0];
        assign res[4*g + 1]   = conv[g*PER_DIR + 1];
        assign res[4*g + 2]   = conv[g*PER_DIR + 3];
        assign res[4*g + 3]   = conv[g*PER_DIR + 4];
        assign res[OUT_TOT + g] = CYC_W'(widest);
    end

endmodule

// File: rtl/mem_timing_calc.sv
module mem_timing_calc
    import mem_timing_pkg::*;
#(
    parameter int CLK_W     = 32,
    parameter int NS_W      = 16,
    parameter int CYC_W     = 24,
    parameter int FRAC_W    = 16,
    parameter int PRE_DIV   = 10000,
    parameter int SCALE_DIV = 100000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CLK_W-1:0]         clk_hz,
    input  logic [NUM_REQ*NS_W-1:0]  req_ns,
    output logic [NUM_OUT*CYC_W-1:0] cyc_out,
    output logic                     done
);
    localparam int MUL_W  = CLK_W;
    localparam int DW     = CLK_W + FRAC_W;
    localparam int VW_PRE = $clog2(PRE_DIV + 1);
    localparam int VW_SCL = $clog2(SCALE_DIV + 1);
    localparam int VW     = (VW_PRE > VW_SCL) ? VW_PRE : VW_SCL;
    localparam int IDX_W  = $clog2(NUM_REQ);
    localparam int SW     = CYC_W + 2;

    typedef struct packed {
        calc_state_e                   state;
        logic [CLK_W-1:0]              hz;
        logic [CLK_W-1:0]              pre;
        logic [MUL_W-1:0]              mul;
        logic [NUM_REQ-1:0][NS_W-1:0]  req;
        logic [NUM_REQ-1:0][CYC_W-1:0] conv;
        logic [IDX_W-1:0]              idx;
        logic [NUM_OUT-1:0][CYC_W-1:0] res;
        logic                          div_go;
        logic                          done;
    } calc_regs_t;

    calc_regs_t q, d;

    logic [DW-1:0]                 div_dividend;
    logic [VW-1:0]                 div_divisor;
    logic [CLK_W-1:0]              div_quo;
    logic                          div_done;
    logic [CYC_W-1:0]              slot_cyc;
    logic                          slot_recovery;
    logic [NUM_OUT-1:0][CYC_W-1:0] fit_res;

    // Two passes through one divider: rate / PRE_DIV, then (that << FRAC_W) / SCALE_DIV.
    always_comb begin
        if (q.state == CS_PRE) begin
            div_dividend = DW'(q.hz);
            div_divisor  = VW'(PRE_DIV);
        end else begin
            div_dividend = {q.pre, {FRAC_W{1'b0}}};
            div_divisor  = VW'(SCALE_DIV);
        end
    end

    seq_divider #(
        .DW (DW),
        .VW (VW),
        .QW (CLK_W)
    ) i_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (q.div_go),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .quotient (div_quo),
        .done     (div_done)
    );

    assign slot_recovery = is_recovery_slot(32'(q.idx));

    ns_to_cycles #(
        .NS_W   (NS_W),
        .MUL_W  (MUL_W),
        .CYC_W  (CYC_W),
        .FRAC_W (FRAC_W)
    ) i_convert (
        .ns       (q.req[q.idx]),
        .mul      (q.mul),
        .recovery (slot_recovery),
        .cyc      (slot_cyc)
    );

    fit_totals #(
        .CYC_W (CYC_W)
    ) i_fit (
        .conv (q.conv),
        .res  (fit_res)
    );

    always_comb begin
        d        = q;
        d.div_go = 1'b0;
        d.done   = 1'b0;
        unique case (q.state)
            CS_IDLE: begin
                if (start) begin
                    d.hz     = clk_hz;
                    d.req    = req_ns;
                    d.div_go = 1'b1;
                    d.state  = CS_PRE;
                end
            end
            CS_PRE: begin
                if (div_done) begin
                    d.pre    = div_quo;
                    d.div_go = 1'b1;
                    d.state  = CS_SCALE;
                end
            end
            CS_SCALE: begin
                if (div_done) begin
                    d.mul   = div_quo;
                    d.idx   = '0;
                    d.state = CS_CONV;
                end
            end
            CS_CONV: begin
                d.conv[q.idx] = slot_cyc;
                if (q.idx == IDX_W'(NUM_REQ - 1)) d.state = CS_FIT;
                else                              d.idx   = q.idx + 1'b1;
            end
            CS_FIT: begin
                d.res   = fit_res;
                d.done  = 1'b1;
                d.state = CS_IDLE;
            end
            default: d.state = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cyc_out = q.res;
    assign done    = q.done;

    // Port-level views for the checks below.
    logic [SW-1:0] chk_rd_cs, chk_rd_st, chk_wr_cs, chk_wr_st, chk_rd_tot, chk_wr_tot;
    assign chk_rd_cs  = SW'(cyc_out[0*CYC_W +: CYC_W]) + SW'(cyc_out[1*CYC_W +: CYC_W]);
    assign chk_rd_st  = SW'(cyc_out[2*CYC_W +: CYC_W]) + SW'(cyc_out[3*CYC_W +: CYC_W]);
    assign chk_wr_cs  = SW'(cyc_out[4*CYC_W +: CYC_W]) + SW'(cyc_out[5*CYC_W +: CYC_W]);
    assign chk_wr_st  = SW'(cyc_out[6*CYC_W +: CYC_W]) + SW'(cyc_out[7*CYC_W +: CYC_W]);
    assign chk_rd_tot = SW'(cyc_out[8*CYC_W +: CYC_W]);
    assign chk_wr_tot = SW'(cyc_out[9*CYC_W +: CYC_W]);

    // R5 with R4: the read total leaves at least one recovery cycle after each read strobe.
    assert_rd_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_rd_tot > chk_rd_cs) && (chk_rd_tot > chk_rd_st));

    // R6 with R4: the same for the write direction.
    assert_wr_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_wr_tot > chk_wr_cs) && (chk_wr_tot > chk_wr_st));

    // R7: done never lasts two cycles.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: results only move together with done.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cyc_out));

    // R8: a start seen while busy leaves the captured rate untouched.
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != CS_IDLE && start) |=> $stable(q.hz));

endmodule

// File: tb/test_mem_timing_calc.sv
module test_mem_timing_calc;
    localparam int NR = 14;
    localparam int NO = 10;
    localparam int NW = 16;
    localparam int CW = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       clk_hz = '0;
    logic [NR*NW-1:0]  req_ns = '0;
    logic [NO*CW-1:0]  cyc_out;
    logic              done;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] rq [NR];
    logic [63:0] ex [NO];
    logic [63:0] hz_val;

    always #10 clk = ~clk;

    mem_timing_calc i_mem_timing_calc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .clk_hz  (clk_hz),
        .req_ns  (req_ns),
        .cyc_out (cyc_out),
        .done    (done)
    );

    function automatic logic [63:0] out_slot(input int j);
        return 64'(cyc_out[j*CW +: CW]);
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic logic [63:0] cvt(input logic [63:0] hz, input logic [63:0] ns, input bit recov);
        logic [63:0] mul;
        mul = ((hz / 64'd10000) << 16) / 64'd100000;
        if (ns == 0) return recov ? 64'd1 : 64'd0;
        return (ns * mul + 64'd65535) >> 16;
    endfunction

    task automatic model();
        logic [63:0] c [NR];
        for (int k = 0; k < NR; k++) c[k] = cvt(hz_val, rq[k], (k < 12) && (k % 3 == 2));
        for (int g = 0; g < 2; g++) begin
            logic [63:0] m;
            ex[4*g+0] = c[6*g+0];
            ex[4*g+1] = c[6*g+1];
            ex[4*g+2] = c[6*g+3];
            ex[4*g+3] = c[6*g+4];
            m = c[12+g];
            if (c[6*g+0] + c[6*g+1] + c[6*g+2] > m) m = c[6*g+0] + c[6*g+1] + c[6*g+2];
            if (c[6*g+3] + c[6*g+4] + c[6*g+5] > m) m = c[6*g+3] + c[6*g+4] + c[6*g+5];
            ex[8+g] = m;
        end
    endtask

    task automatic drive_inputs();
        clk_hz = hz_val[31:0];
        for (int k = 0; k < NR; k++) req_ns[k*NW +: NW] = rq[k][NW-1:0];
    endtask

    task automatic pulse_start();
        @(negedge clk);
        drive_inputs();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit seen = 0;
        for (int t = 0; t < 2000 && !seen; t++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check(tag, "done seen", 64'(seen), 64'd1);
        @(negedge clk);
        check("R7", "done one cycle", 64'(done), 64'd0);
    endtask

    task automatic compare_all(input string tag);
        for (int j = 0; j < 8; j++) check(tag, $sformatf("slot %0d", j), out_slot(j), ex[j]);
        check("R5", "read total", out_slot(8), ex[8]);
        check("R6", "write total", out_slot(9), ex[9]);
    endtask

    task automatic run_case(input string tag);
        model();
        pulse_start();
        wait_done(tag);
        compare_all(tag);
    endtask

    task automatic set_all(input logic [63:0] v);
        for (int k = 0; k < NR; k++) rq[k] = v;
    endtask

    task automatic t_reset();
        check("R9", "done at reset", 64'(done), 64'd0);
        check("R9", "outputs at reset", 64'(|cyc_out), 64'd0);
    endtask

    task automatic t_typical();
        hz_val = 100_000_000;
        rq = '{5, 20, 10, 10, 30, 0, 0, 25, 5, 7, 40, 0, 60, 0};
        run_case("R2");
        check("R3", "zero setup stays zero", out_slot(4), 64'd0);
    endtask

    task automatic t_all_zero();
        hz_val = 50_000_000;
        set_all(0);
        run_case("R3");
        check("R4", "read total from default recovery", out_slot(8), 64'd1);
        check("R4", "write total from default recovery", out_slot(9), 64'd1);
    endtask

    task automatic t_total_dominant();
        hz_val = 66_000_000;
        rq = '{3, 9, 4, 2, 11, 6, 1, 8, 3, 2, 12, 5, 1000, 900};
        run_case("R1");
    endtask

    task automatic t_stretch();
        hz_val = 133_333_333;
        rq = '{15, 60, 0, 5, 80, 25, 20, 70, 12, 9, 90, 33, 10, 10};
        run_case("R5");
        check("R6", "write total above request", 64'(out_slot(9) > cvt(hz_val, 10, 0)), 64'd1);
    endtask

    task automatic t_rounding();
        // 250 MHz: multiplier 16384, 3 ns is 0.75 cycle -> 1.  1 GHz: multiplier 65536, exact.
        hz_val = 250_000_000;
        set_all(0);
        rq[0] = 3;
        rq[1] = 8;
        run_case("R2");
        check("R2", "fraction rounds up", out_slot(0), 64'd1);
        check("R2", "exact two cycles", out_slot(1), 64'd2);
        hz_val = 1_000_000_000;
        rq[0] = 7;
        rq[1] = 0;
        run_case("R2");
        check("R2", "exact multiple no extra", out_slot(0), 64'd7);
    endtask

    task automatic t_extreme();
        hz_val = 64'hFFFF_FFFF;
        set_all(65535);
        run_case("R1");
    endtask

    task automatic t_hold();
        logic [NO*CW-1:0] snap;
        snap = cyc_out;
        @(negedge clk);
        clk_hz = 32'd12345;
        req_ns = {NR*NW{1'b1}};
        for (int t = 0; t < 20; t++) @(negedge clk);
        check("R7", "outputs held", 64'(cyc_out == snap), 64'd1);
    endtask

    task automatic t_busy_restart();
        logic [63:0] keep [NO];
        int extra = 0;
        hz_val = 80_000_000;
        rq = '{4, 30, 6, 8, 22, 0, 3, 27, 0, 6, 35, 9, 20, 0};
        model();
        keep = ex;
        pulse_start();
        for (int t = 0; t < 30; t++) @(negedge clk);
        hz_val = 20_000_000;
        set_all(500);
        pulse_start();
        wait_done("R8");
        ex = keep;
        compare_all("R8");
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R8", "no queued run", 64'(extra), 64'd0);
    endtask

    initial begin
        for (int t = 0; t < 200_000; t++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int t = 0; t < 4; t++) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_typical();
        t_hold();
        t_all_zero();
        t_total_dominant();
        t_stretch();
        t_rounding();
        t_extreme();
        t_busy_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule